// File: doc/BRIEF.md
# Indirect Configuration Window with Keyed Soft Reset

This block is the host-facing register front end of a serial bus controller. The host sees four byte-wide locations on a small synchronous parallel bus. One of them is a pointer, one is a data window onto the internal configuration register that the pointer selects, and one is a reset entry. Every internal register is reached in two steps: the host writes the register index to the pointer, then reads or writes the data window.

The internal set holds five registers: the controller's own bus address, a timeout count, a two-bit speed mode, and the low and high phase counts of the serial clock. Their current values drive the controller core through dedicated outputs.

A soft reset of the core is guarded by a two-byte unlock key written to the reset entry. When the key is complete, the block issues a one-cycle reset pulse. In the same edge it returns every internal register to its default and clears the pointer, so the clock and mode settings must be written again afterwards.

Top module: `ind_reg_window`

## Requirements
- R1: Host byte locations are selected by `addr_i`: 0 is the pointer, 1 is the data window, 2 is the reset entry and 3 is unused. Internal indices are 0 own address, 1 timeout, 2 mode, 3 clock-low count and 4 clock-high count. A write to the data window stores `wdata_i` into the register that the pointer selects, and the matching output shows the new value in the cycle after the write edge.
- R2: A read strobe registers its result into `rdata_o` at the next clock edge, which is one cycle of latency. A data window read returns the selected register. `rdata_o` holds its value between reads.
- R3: The own-address and timeout registers are independent. Each reads back the last value written to it, whatever was written to the other.
- R4: The mode register keeps only bits [1:0] (0 standard, 1 fast, 2 fast-plus, 3 turbo). Its upper bits are dropped on a write and read back as 0.
- R5: A write of 0xA5 to the reset entry followed directly by a write of 0x5A to the reset entry raises `soft_rst_o` for exactly one cycle. That cycle is the one after the 0x5A write edge.
- R6: The soft reset returns all five internal registers to their default parameter values and clears the pointer to 0. All of these are visible in the same cycle as the pulse.
- R7: The key returns to waiting for 0xA5 in two cases: the write after 0xA5 to the reset entry is any value other than 0x5A, or a write goes to any other host location in between. A second 0xA5 keeps the sequence ready for 0x5A. Reads do not disturb the sequence.
- R8: When the pointer holds an undefined index (5 to 7), a data window read returns 0x00 and a data window write changes no register.
- R9: The pointer stores `wdata_i[2:0]` and reads back at location 0 with its upper bits as 0. Reads of locations 2 and 3 return 0x00.
- R10: While `rst_ni` is low, the internal registers take their defaults, the pointer and `rdata_o` are 0, and `soft_rst_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Host location select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after `rd_i` |
| own_addr_o | output | 8 | Own bus address register |
| timeout_o | output | 8 | Timeout register |
| mode_o | output | 2 | Speed mode register |
| scl_lo_o | output | 8 | Serial clock low count |
| scl_hi_o | output | 8 | Serial clock high count |
| soft_rst_o | output | 1 | One-cycle soft reset pulse to the core |

## Verification
The bench builds the block with a nonzero, distinct default for each internal register, for example timeout 0xC8 and mode 2. A soft reset is therefore told apart from a plain clear to zero, and a restored register is told apart from one left with its programmed value. The random phase weights the reset entry toward the two key bytes. This makes complete keys, broken keys and interleaved writes frequent, and pointer values cover both defined and undefined indices.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned HOST_AW  = 2;
  localparam int unsigned PTR_W    = 3;
  localparam int unsigned NUM_REGS = 5;
  localparam int unsigned MODE_W   = 2;

  localparam logic [HOST_AW-1:0] HA_PTR  = 2'd0;
  localparam logic [HOST_AW-1:0] HA_DATA = 2'd1;
  localparam logic [HOST_AW-1:0] HA_KEY  = 2'd2;

  localparam int unsigned IDX_OWN  = 0;
  localparam int unsigned IDX_TMO  = 1;
  localparam int unsigned IDX_MODE = 2;
  localparam int unsigned IDX_LO   = 3;
  localparam int unsigned IDX_HI   = 4;

  localparam logic [DW-1:0] KEY_FIRST  = 8'hA5;
  localparam logic [DW-1:0] KEY_SECOND = 8'h5A;

  typedef logic [NUM_REGS-1:0][DW-1:0] reg_bank_t;
endpackage

// File: rtl/iwin_key_seq.sv
module iwin_key_seq
  import iwin_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic               fire_o,
  output logic               soft_rst_o
);
  logic armed_q;
  logic key_wr;

  assign key_wr = wr_i && (addr_i == HA_KEY);
  assign fire_o = key_wr && armed_q && (wdata_i == KEY_SECOND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      soft_rst_o <= 1'b0;
    end else begin
      soft_rst_o <= fire_o;
      // any write re-evaluates the arming; only 0xA5 to the key entry arms
      if (wr_i) armed_q <= key_wr && (wdata_i == KEY_FIRST);
    end
  end

  a_r5_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);
  a_r5_pulse_after_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> $past(wr_i && addr_i == HA_KEY && wdata_i == KEY_SECOND));
  a_r7_other_write_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i != HA_KEY) |=> !armed_q);
endmodule

// File: rtl/iwin_regfile.sv
module iwin_regfile
  import iwin_pkg::*;
#(
  parameter reg_bank_t DEFS = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ptr_we_i,
  input  logic             data_we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [PTR_W-1:0] ptr_o,
  output reg_bank_t        regs_o,
  output logic [DW-1:0]    sel_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (clr_i)    ptr_q <= '0;
    else if (ptr_we_i) ptr_q <= wdata_i[PTR_W-1:0];
  end
  assign ptr_o = ptr_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DW-1:0] MASK = (i == IDX_MODE) ?
      {{(DW-MODE_W){1'b0}}, {MODE_W{1'b1}}} : {DW{1'b1}};
    localparam logic [DW-1:0] DEF = DEFS[i] & MASK;
    logic hit;
    assign hit = data_we_i && (ptr_q == PTR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    regs_o[i] <= DEF;
      else if (clr_i) regs_o[i] <= DEF;
      else if (hit)   regs_o[i] <= wdata_i & MASK;
    end
  end

  always_comb begin
    sel_o = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (ptr_q == PTR_W'(k)) sel_o = regs_o[k];
  end

  a_r6_clear_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ptr_q == '0) && (regs_o[IDX_OWN] == DEFS[IDX_OWN])
              && (regs_o[IDX_LO] == DEFS[IDX_LO]) && (regs_o[IDX_HI] == DEFS[IDX_HI]));
  a_r8_undef_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !clr_i && ptr_q >= PTR_W'(NUM_REGS)) |=> $stable(regs_o));
  a_r4_mode_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> (regs_o[IDX_MODE][DW-1:MODE_W] == '0));
endmodule

// File: rtl/ind_reg_window.sv
module ind_reg_window
  import iwin_pkg::*;
#(
  parameter logic [7:0] OWN_DEF  = 8'h00,
  parameter logic [7:0] TMO_DEF  = 8'hFF,
  parameter logic [1:0] MODE_DEF = 2'd0,
  parameter logic [7:0] LO_DEF   = 8'h9D,
  parameter logic [7:0] HI_DEF   = 8'h86
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   addr_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [7:0]   wdata_i,
  output logic [7:0]   rdata_o,
  output logic [7:0]   own_addr_o,
  output logic [7:0]   timeout_o,
  output logic [1:0]   mode_o,
  output logic [7:0]   scl_lo_o,
  output logic [7:0]   scl_hi_o,
  output logic         soft_rst_o
);
  localparam reg_bank_t DEFS = {HI_DEF, LO_DEF, {6'd0, MODE_DEF}, TMO_DEF, OWN_DEF};

  logic             fire;
  logic [PTR_W-1:0] ptr;
  reg_bank_t        regs;
  logic [DW-1:0]    sel;
  logic [DW-1:0]    rd_val;

  iwin_key_seq u_key (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .fire_o(fire), .soft_rst_o
  );

  iwin_regfile #(.DEFS(DEFS)) u_regs (
    .clk_i, .rst_ni,
    .clr_i    (fire),
    .ptr_we_i (wr_i && addr_i == HA_PTR),
    .data_we_i(wr_i && addr_i == HA_DATA),
    .wdata_i,
    .ptr_o    (ptr),
    .regs_o   (regs),
    .sel_o    (sel)
  );

  always_comb begin
    unique case (addr_i)
      HA_PTR:  rd_val = {{(DW-PTR_W){1'b0}}, ptr};
      HA_DATA: rd_val = sel;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end

  assign own_addr_o = regs[IDX_OWN];
  assign timeout_o  = regs[IDX_TMO];
  assign mode_o     = regs[IDX_MODE][MODE_W-1:0];
  assign scl_lo_o   = regs[IDX_LO];
  assign scl_hi_o   = regs[IDX_HI];

  a_r2_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  a_r9_unused_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[1]) |=> (rdata_o == 8'h00));
endmodule

// File: tb/ind_reg_window_bench.sv
`timescale 1ns/1ps
module ind_reg_window_bench;
  localparam logic [7:0] OWN_D = 8'h3C, TMO_D = 8'hC8, LO_D = 8'h9D, HI_D = 8'h86;
  localparam logic [1:0] MODE_D = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, own, tmo, lo, hi;
  logic [1:0] mode;
  logic srst;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_reg [5];
  logic [2:0] m_ptr;
  bit m_armed, m_fire;

  always #2.5 clk = ~clk;

  ind_reg_window #(.OWN_DEF(OWN_D), .TMO_DEF(TMO_D), .MODE_DEF(MODE_D),
                   .LO_DEF(LO_D), .HI_DEF(HI_D)) u_ind_reg_window (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .own_addr_o(own), .timeout_o(tmo),
    .mode_o(mode), .scl_lo_o(lo), .scl_hi_o(hi), .soft_rst_o(srst));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic m_defaults();
    m_reg[0] = OWN_D; m_reg[1] = TMO_D; m_reg[2] = {6'd0, MODE_D};
    m_reg[3] = LO_D;  m_reg[4] = HI_D;  m_ptr = 3'd0; m_armed = 0;
  endtask

  function automatic logic [7:0] m_read(input logic [1:0] a);
    if (a == 2'd0) return {5'd0, m_ptr};
    if (a == 2'd1) return (m_ptr < 3'd5) ? m_reg[m_ptr] : 8'h00;
    return 8'h00;
  endfunction

  task automatic chk_outs(input string req);
    chk({req, " own"},  own,  m_reg[0]);
    chk({req, " tmo"},  tmo,  m_reg[1]);
    chk({req, " mode"}, mode, m_reg[2]);
    chk({req, " lo"},   lo,   m_reg[3]);
    chk({req, " hi"},   hi,   m_reg[4]);
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d, input string req);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    m_fire = m_armed && a == 2'd2 && d == 8'h5A;
    if (m_fire) m_defaults();
    else begin
      if (a == 2'd0) m_ptr = d[2:0];
      if (a == 2'd1 && m_ptr < 3'd5) m_reg[m_ptr] = (m_ptr == 3'd2) ? (d & 8'h03) : d;
      m_armed = (a == 2'd2 && d == 8'hA5);
    end
    chk({req, " pulse"}, srst, m_fire);
    chk_outs(req);
  endtask

  task automatic host_rd(input logic [1:0] a, input string req);
    logic [7:0] e;
    e = m_read(a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk({req, " rdata"}, rdata, e);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_defaults();
    #12;
    // R10 reset state
    chk("R10 rdata", rdata, 0); chk("R10 pulse", srst, 0); chk_outs("R10");
    @(negedge clk); rst_n = 1'b1;
    host_rd(2'd0, "R10 ptr");

    // R1 / R2 / R3
    host_wr(2'd0, 8'd0, "R1");  host_wr(2'd1, 8'h42, "R1 own");
    host_wr(2'd0, 8'd1, "R3");  host_wr(2'd1, 8'h00, "R3 tmo");
    host_wr(2'd0, 8'd0, "R3");  host_rd(2'd1, "R3 own readback");
    host_wr(2'd0, 8'd1, "R2");  host_rd(2'd1, "R2 tmo readback");
    // R2 hold: rdata stays without read strobe
    @(negedge clk); chk("R2 hold", rdata, 8'h00);
    host_wr(2'd0, 8'd3, "R1"); host_wr(2'd1, 8'h21, "R1 lo");
    host_wr(2'd0, 8'd4, "R1"); host_wr(2'd1, 8'h17, "R1 hi");
    // R4 mode masking
    host_wr(2'd0, 8'd2, "R4"); host_wr(2'd1, 8'hFF, "R4 mode");
    host_rd(2'd1, "R4 mode readback");
    // R8 undefined index
    host_wr(2'd0, 8'd6, "R8"); host_wr(2'd1, 8'h77, "R8 write ignored");
    host_rd(2'd1, "R8 read zero");
    // R9 pointer masking, unused locations
    host_wr(2'd0, 8'hFD, "R9"); host_rd(2'd0, "R9 ptr");
    host_rd(2'd2, "R9 key read"); host_rd(2'd3, "R9 spare read");
    // R7 broken keys
    host_wr(2'd2, 8'hA5, "R7"); host_wr(2'd2, 8'h11, "R7 wrong");
    host_wr(2'd2, 8'h5A, "R7 no pulse after wrong");
    host_wr(2'd2, 8'hA5, "R7"); host_wr(2'd0, 8'd1, "R7 interleave");
    host_wr(2'd2, 8'h5A, "R7 no pulse after interleave");
    host_wr(2'd2, 8'hA5, "R7"); host_rd(2'd1, "R7 read keeps key");
    host_wr(2'd2, 8'hA5, "R7 double"); 
    // R5 / R6 complete key
    host_wr(2'd2, 8'h5A, "R5 R6 key");
    @(negedge clk); chk("R5 single cycle", srst, 0);
    host_rd(2'd0, "R6 ptr cleared");
    host_rd(2'd1, "R6 own default");

    // random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] d;
      op = $urandom_range(0, 9);
      d = 8'($urandom);
      case (op)
        0, 1: host_wr(2'd0, d, "R1 R9 rnd ptr");
        2, 3: host_wr(2'd1, d, "R1 R4 R8 rnd data");
        4, 5: host_rd(2'($urandom_range(0, 3)), "R2 rnd read");
        6:    host_wr(2'd2, 8'hA5, "R7 rnd key1");
        7:    host_wr(2'd2, 8'h5A, "R5 rnd key2");
        8:    host_wr(2'd2, d, "R7 rnd key other");
        default: host_wr(2'd3, d, "R7 rnd spare");
      endcase
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule